// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block is the register-transfer front end of a memory-management and cache control coprocessor. A processor pipeline hands it one coprocessor transfer per cycle: a 32-bit instruction word, a valid strobe, a direction bit (move-to or move-from the coprocessor) and the write operand. The bank decodes the register number and the two sub-opcode fields from the instruction. It then does one of four things: it returns a register value, it stores a masked write, it raises a one-cycle maintenance pulse, or it flags the transfer as undefined.

The stored fields leave the block as plain outputs that feed the MMU: main control, auxiliary control, translation base, domain access, fault status, fault address, process identifier and coprocessor access rights. Maintenance writes are not stored. They become pulses on a vector that the caches, the TLBs and the write buffer consume, and the written value travels with each pulse as its address operand. The ID and cache-type words are constants set by parameters.

Top module: `sysctl_cp_regbank`

## Requirements
- R1: The register number is taken from instruction bits [19:16], the sub-opcode (op2) from bits [7:5] and the minor field (crm) from bits [3:0]. No other instruction bit affects behaviour. req_write=1 is a move-to (write) and req_write=0 is a move-from (read).
- R2: A read of register 0 returns the cache-type constant when op2 is nonzero, and the ID constant when op2 is zero. Every read result appears on rd_data_o in the cycle after the request and holds until the next legal read.
- R3: Register 1 is split by op2. A write with op2=0 stores wdata & 0x3FFF in main control, and a write with op2 nonzero stores wdata & 0x33 in auxiliary control. Reads are selected by op2 in the same way.
- R4: Writes keep only masked bits: register 2 (translation base) keeps 0xFFFFC000, register 5 (fault status) keeps 0x6FF, register 13 (process ID) keeps 0xFE000000 and register 15 (access rights) keeps 0x3FF. The new value is visible on the field output in the cycle after the write.
- R5: Register 3 (domain access) and register 6 (fault address) store all 32 bits.
- R6: On a write to register 7, the pair (op2,crm) drives maint_pulse_o as follows. Bit positions: 0 I-cache invalidate all, 1 I-cache invalidate line, 2 D-cache invalidate all, 3 D-cache invalidate line, 4 D-cache clean line. Pulses: (0,7) sets bits 0 and 2; (0,5) sets bit 0; (1,5) sets bit 1; (0,6) sets bit 2; (1,6) sets bit 3; (1,10) sets bit 4; (4,10) sets bit 5 (write-buffer drain); (5,2) sets bit 2.
- R7: On a write to register 8, (op2,crm) drives maint_pulse_o as follows. Bit positions: 6 instruction-TLB invalidate all, 7 instruction-TLB invalidate entry, 8 data-TLB invalidate all, 9 data-TLB invalidate entry. Pulses: (0,7) sets bits 6 and 8; (0,5) sets bit 6; (1,5) sets bit 7; (0,6) sets bit 8; (1,6) sets bit 9.
- R8: Each maintenance pulse is high for exactly the one cycle after its request, and maint_operand_o carries that request's write data in the same cycle.
- R9: undef_o pulses for one cycle after a write to register 7 or 8 whose (op2,crm) is not listed in R6/R7/R11. It also pulses after a read of any register other than 0, 1, 2, 3, 5, 6, 13 or 15. Such a request changes no stored field, raises no pulse and leaves rd_data_o unchanged.
- R10: A write to any register other than 1, 2, 3, 5, 6, 7, 8, 13 or 15 (this includes register 0) is ignored: no field changes and undef_o stays low.
- R11: A write of (6,5) to register 7 (branch-target flush) is accepted with no pulse and no undef_o.
- R12: A read of register 13 returns the process ID alone, not the access-rights value.
- R13: After reset all stored fields, rd_data_o, undef_o, maint_pulse_o and maint_operand_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request strobe |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_instr | input | 32 | Coprocessor instruction word |
| req_wdata | input | 32 | Write data / maintenance operand |
| rd_data_o | output | 32 | Result of the last legal read |
| undef_o | output | 1 | One-cycle undefined-access flag |
| maint_pulse_o | output | 10 | One-cycle maintenance pulses (bit map in R6/R7) |
| maint_operand_o | output | 32 | Operand accompanying the maintenance pulses |
| ctl_main_o | output | 32 | Main control field |
| ctl_aux_o | output | 32 | Auxiliary control field |
| ttb_o | output | 32 | Translation table base |
| dom_o | output | 32 | Domain access rights |
| fstat_o | output | 32 | Fault status |
| faddr_o | output | 32 | Fault address |
| pid_o | output | 32 | Process identifier |
| cpacc_o | output | 32 | Coprocessor access rights |

## Verification
The bench goes after the op2 splits on registers 0 and 1. A design that ignored op2 there would return the ID word for the cache type, or write main control where auxiliary control was meant. It sweeps every legal and several illegal (op2,crm) pairs on registers 7 and 8, and fills the don't-care instruction bits with random values. A decoder that is one bit off, or that reads a neighbouring field, then fires the wrong pulse or misses undef_o. It also covers the process-ID read right after an access-rights write, writes to read-only and unknown registers, back-to-back maintenance writes, and the branch-target flush. A fall-through read, a stray state change or a stretched pulse each shows up as a mismatch against the model in that cycle.

// File: rtl/sysctl_cp_pkg.sv
package sysctl_cp_pkg;

  // Register numbers seen in instruction bits [19:16]
  localparam logic [3:0] CRN_IDENT = 4'd0;
  localparam logic [3:0] CRN_CTRL  = 4'd1;
  localparam logic [3:0] CRN_TTB   = 4'd2;
  localparam logic [3:0] CRN_DOM   = 4'd3;
  localparam logic [3:0] CRN_FSTAT = 4'd5;
  localparam logic [3:0] CRN_FADDR = 4'd6;
  localparam logic [3:0] CRN_CACHE = 4'd7;
  localparam logic [3:0] CRN_TLB   = 4'd8;
  localparam logic [3:0] CRN_PID   = 4'd13;
  localparam logic [3:0] CRN_CPACC = 4'd15;

  // Stored-field slots
  localparam int RI_CTRL  = 0;
  localparam int RI_AUX   = 1;
  localparam int RI_TTB   = 2;
  localparam int RI_DOM   = 3;
  localparam int RI_FSTAT = 4;
  localparam int RI_FADDR = 5;
  localparam int RI_PID   = 6;
  localparam int RI_CPACC = 7;
  localparam int NREG     = 8;
  localparam int RIDX_W   = $clog2(NREG);

  // Maintenance pulse bit map
  localparam int MOP_IC_ALL   = 0;
  localparam int MOP_IC_LINE  = 1;
  localparam int MOP_DC_ALL   = 2;
  localparam int MOP_DC_LINE  = 3;
  localparam int MOP_DC_CLEAN = 4;
  localparam int MOP_WB_DRAIN = 5;
  localparam int MOP_IT_ALL   = 6;
  localparam int MOP_IT_ONE   = 7;
  localparam int MOP_DT_ALL   = 8;
  localparam int MOP_DT_ONE   = 9;
  localparam int MOP_W        = 10;

  typedef struct packed {
    logic [3:0] crn;
    logic [2:0] op2;
    logic [3:0] crm;
  } cp_field_t;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_ID,
    RK_CTYPE,
    RK_REG
  } rd_kind_e;

  function automatic cp_field_t split_instr(input logic [31:0] instr);
    cp_field_t f;
    f.crn = instr[19:16];
    f.op2 = instr[7:5];
    f.crm = instr[3:0];
    return f;
  endfunction

endpackage

// File: rtl/cp_decode.sv
module cp_decode
  import sysctl_cp_pkg::*;
(
  input  logic              valid,
  input  logic              write,
  input  logic [31:0]       instr,
  output logic [NREG-1:0]   wen,
  output rd_kind_e          rd_kind,
  output logic [RIDX_W-1:0] rd_idx,
  output logic [MOP_W-1:0]  mop,
  output logic              undef
);

  cp_field_t fld;
  logic      op2_nz;

  always_comb begin
    fld     = split_instr(instr);
    op2_nz  = (fld.op2 != 3'd0);
    wen     = '0;
    rd_kind = RK_NONE;
    rd_idx  = '0;
    mop     = '0;
    undef   = 1'b0;
    if (valid && write) begin
      case (fld.crn)
        CRN_CTRL:  if (op2_nz) wen[RI_AUX] = 1'b1; else wen[RI_CTRL] = 1'b1;
        CRN_TTB:   wen[RI_TTB]   = 1'b1;
        CRN_DOM:   wen[RI_DOM]   = 1'b1;
        CRN_FSTAT: wen[RI_FSTAT] = 1'b1;
        CRN_FADDR: wen[RI_FADDR] = 1'b1;
        CRN_PID:   wen[RI_PID]   = 1'b1;
        CRN_CPACC: wen[RI_CPACC] = 1'b1;
        CRN_CACHE: begin
          case ({fld.op2, fld.crm})
            {3'd0, 4'd7}:  begin mop[MOP_IC_ALL] = 1'b1; mop[MOP_DC_ALL] = 1'b1; end
            {3'd0, 4'd5}:  mop[MOP_IC_ALL]   = 1'b1;
            {3'd1, 4'd5}:  mop[MOP_IC_LINE]  = 1'b1;
            {3'd0, 4'd6}:  mop[MOP_DC_ALL]   = 1'b1;
            {3'd1, 4'd6}:  mop[MOP_DC_LINE]  = 1'b1;
            {3'd1, 4'd10}: mop[MOP_DC_CLEAN] = 1'b1;
            {3'd4, 4'd10}: mop[MOP_WB_DRAIN] = 1'b1;
            {3'd5, 4'd2}:  mop[MOP_DC_ALL]   = 1'b1;
            {3'd6, 4'd5}:  ;
            default:       undef = 1'b1;
          endcase
        end
        CRN_TLB: begin
          case ({fld.op2, fld.crm})
            {3'd0, 4'd7}: begin mop[MOP_IT_ALL] = 1'b1; mop[MOP_DT_ALL] = 1'b1; end
            {3'd0, 4'd5}: mop[MOP_IT_ALL] = 1'b1;
            {3'd1, 4'd5}: mop[MOP_IT_ONE] = 1'b1;
            {3'd0, 4'd6}: mop[MOP_DT_ALL] = 1'b1;
            {3'd1, 4'd6}: mop[MOP_DT_ONE] = 1'b1;
            default:      undef = 1'b1;
          endcase
        end
        default: ;
      endcase
    end else if (valid) begin
      rd_kind = RK_REG;
      case (fld.crn)
        CRN_IDENT: rd_kind = op2_nz ? RK_CTYPE : RK_ID;
        CRN_CTRL:  rd_idx  = op2_nz ? RIDX_W'(RI_AUX) : RIDX_W'(RI_CTRL);
        CRN_TTB:   rd_idx  = RIDX_W'(RI_TTB);
        CRN_DOM:   rd_idx  = RIDX_W'(RI_DOM);
        CRN_FSTAT: rd_idx  = RIDX_W'(RI_FSTAT);
        CRN_FADDR: rd_idx  = RIDX_W'(RI_FADDR);
        CRN_PID:   rd_idx  = RIDX_W'(RI_PID);
        CRN_CPACC: rd_idx  = RIDX_W'(RI_CPACC);
        default: begin
          rd_kind = RK_NONE;
          undef   = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/cp_mreg.sv
module cp_mreg #(
  parameter int unsigned     DW   = 32,
  parameter logic [DW-1:0]   MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  logic [DW-1:0] q_r;
  logic [DW-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en) q_nxt = d & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

endmodule

// File: rtl/cp_maint.sv
module cp_maint #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] mop_nxt,
  input  logic [DW-1:0] wdata,
  output logic [NW-1:0] pulse,
  output logic [DW-1:0] operand
);

  logic [NW-1:0] pulse_r;
  logic [DW-1:0] oper_r;
  logic [DW-1:0] oper_nxt;
  logic          oper_en;

  always_comb begin
    oper_en  = |mop_nxt;
    oper_nxt = oper_en ? wdata : oper_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_r <= '0;
      oper_r  <= '0;
    end else begin
      pulse_r <= mop_nxt;
      oper_r  <= oper_nxt;
    end
  end

  assign pulse   = pulse_r;
  assign operand = oper_r;

endmodule

// File: rtl/sysctl_cp_regbank.sv
module sysctl_cp_regbank
  import sysctl_cp_pkg::*;
#(
  parameter int unsigned   DW          = 32,
  parameter logic [DW-1:0] ID_VALUE    = DW'(32'hA5C3_0F17),
  parameter logic [DW-1:0] CTYPE_VALUE = DW'(32'h0B1A_C0DE),
  parameter logic [DW-1:0] MASK_CTRL   = DW'(32'h0000_3FFF),
  parameter logic [DW-1:0] MASK_AUX    = DW'(32'h0000_0033),
  parameter logic [DW-1:0] MASK_TTB    = DW'(32'hFFFF_C000),
  parameter logic [DW-1:0] MASK_DOM    = DW'(32'hFFFF_FFFF),
  parameter logic [DW-1:0] MASK_FSTAT  = DW'(32'h0000_06FF),
  parameter logic [DW-1:0] MASK_FADDR  = DW'(32'hFFFF_FFFF),
  parameter logic [DW-1:0] MASK_PID    = DW'(32'hFE00_0000),
  parameter logic [DW-1:0] MASK_CPACC  = DW'(32'h0000_03FF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [31:0]      req_instr,
  input  logic [DW-1:0]    req_wdata,
  output logic [DW-1:0]    rd_data_o,
  output logic             undef_o,
  output logic [MOP_W-1:0] maint_pulse_o,
  output logic [DW-1:0]    maint_operand_o,
  output logic [DW-1:0]    ctl_main_o,
  output logic [DW-1:0]    ctl_aux_o,
  output logic [DW-1:0]    ttb_o,
  output logic [DW-1:0]    dom_o,
  output logic [DW-1:0]    fstat_o,
  output logic [DW-1:0]    faddr_o,
  output logic [DW-1:0]    pid_o,
  output logic [DW-1:0]    cpacc_o
);

  localparam logic [NREG-1:0][DW-1:0] REG_MASK = {
    MASK_CPACC, MASK_PID, MASK_FADDR, MASK_FSTAT,
    MASK_DOM, MASK_TTB, MASK_AUX, MASK_CTRL};

  // Asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  logic [NREG-1:0]        wen;
  rd_kind_e               rd_kind;
  logic [RIDX_W-1:0]      rd_idx;
  logic [MOP_W-1:0]       mop;
  logic                   undef_nxt;
  logic [NREG-1:0][DW-1:0] reg_q;

  cp_decode u_dec (
    .valid   (req_valid),
    .write   (req_write),
    .instr   (req_instr),
    .wen     (wen),
    .rd_kind (rd_kind),
    .rd_idx  (rd_idx),
    .mop     (mop),
    .undef   (undef_nxt)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_field
    cp_mreg #(.DW(DW), .MASK(REG_MASK[g])) u_reg (
      .clk   (clk),
      .rst_n (rst_int),
      .en    (wen[g]),
      .d     (req_wdata),
      .q     (reg_q[g])
    );
  end

  cp_maint #(.DW(DW), .NW(MOP_W)) u_maint (
    .clk     (clk),
    .rst_n   (rst_int),
    .mop_nxt (mop),
    .wdata   (req_wdata),
    .pulse   (maint_pulse_o),
    .operand (maint_operand_o)
  );

  // Read path and undefined flag
  logic [DW-1:0] rd_r, rd_nxt;
  logic          undef_r;

  always_comb begin
    rd_nxt = rd_r;
    case (rd_kind)
      RK_ID:    rd_nxt = ID_VALUE;
      RK_CTYPE: rd_nxt = CTYPE_VALUE;
      RK_REG:   rd_nxt = reg_q[rd_idx];
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      rd_r    <= '0;
      undef_r <= 1'b0;
    end else begin
      rd_r    <= rd_nxt;
      undef_r <= undef_nxt;
    end
  end

  assign rd_data_o  = rd_r;
  assign undef_o    = undef_r;
  assign ctl_main_o = reg_q[RI_CTRL];
  assign ctl_aux_o  = reg_q[RI_AUX];
  assign ttb_o      = reg_q[RI_TTB];
  assign dom_o      = reg_q[RI_DOM];
  assign fstat_o    = reg_q[RI_FSTAT];
  assign faddr_o    = reg_q[RI_FADDR];
  assign pid_o      = reg_q[RI_PID];
  assign cpacc_o    = reg_q[RI_CPACC];

endmodule

// File: rtl/sysctl_cp_regbank_chk.sv
module sysctl_cp_regbank_chk #(
  parameter int unsigned   DW       = 32,
  parameter int unsigned   NW       = 10,
  parameter logic [DW-1:0] MASK_TTB = DW'(32'hFFFF_C000)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [31:0]   req_instr,
  input logic [DW-1:0] req_wdata,
  input logic [DW-1:0] rd_data_o,
  input logic          undef_o,
  input logic [NW-1:0] maint_pulse_o,
  input logic [DW-1:0] maint_operand_o,
  input logic [DW-1:0] ctl_main_o,
  input logic [DW-1:0] ttb_o
);

  logic wr_any, rd_any, wr_ttb, wr_ctrl, wr_maint, wr_r4;
  assign wr_any   = req_valid && req_write;
  assign rd_any   = req_valid && !req_write;
  assign wr_ttb   = wr_any && (req_instr[19:16] == 4'd2);
  assign wr_ctrl  = wr_any && (req_instr[19:16] == 4'd1);
  assign wr_maint = wr_any && ((req_instr[19:16] == 4'd7) || (req_instr[19:16] == 4'd8));
  assign wr_r4    = wr_any && (req_instr[19:16] == 4'd4);

  // R4: a base write lands masked in the next cycle
  p_ttb_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ttb) |-> (ttb_o == ($past(req_wdata) & MASK_TTB)));

  // R3: main control only moves after a register-1 write
  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_ctrl) |-> $stable(ctl_main_o));

  // R8: a pulse always follows a maintenance-register write
  p_pulse_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|maint_pulse_o) |-> $past(wr_maint));

  // R8: operand equals the data of the request that caused the pulse
  p_operand_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|maint_pulse_o) |-> (maint_operand_o == $past(req_wdata)));

  // R9: an undefined access raises no pulse
  p_undef_nopulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> (maint_pulse_o == '0));

  // R9: undefined flag needs a request one cycle earlier
  p_undef_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> $past(req_valid));

  // R10: writes to an unknown register never flag undefined
  p_unknown_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_r4) |-> !undef_o);

  // R2: read data only changes after a read request
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_any) |-> $stable(rd_data_o));

endmodule

bind sysctl_cp_regbank sysctl_cp_regbank_chk #(
  .DW(DW), .NW(sysctl_cp_pkg::MOP_W), .MASK_TTB(MASK_TTB)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_int),
  .req_valid       (req_valid),
  .req_write       (req_write),
  .req_instr       (req_instr),
  .req_wdata       (req_wdata),
  .rd_data_o       (rd_data_o),
  .undef_o         (undef_o),
  .maint_pulse_o   (maint_pulse_o),
  .maint_operand_o (maint_operand_o),
  .ctl_main_o      (ctl_main_o),
  .ttb_o           (ttb_o)
);

// File: tb/sysctl_cp_regbank_tb_top.sv
`timescale 1ns/1ps
module sysctl_cp_regbank_tb_top;

  localparam logic [31:0] ID_K = 32'hA5C3_0F17;
  localparam logic [31:0] CT_K = 32'h0B1A_C0DE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_instr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data_o, maint_operand_o;
  logic        undef_o;
  logic [9:0]  maint_pulse_o;
  logic [31:0] ctl_main_o, ctl_aux_o, ttb_o, dom_o, fstat_o, faddr_o, pid_o, cpacc_o;

  always #2 clk = ~clk;   // 250 MHz

  sysctl_cp_regbank #(.ID_VALUE(ID_K), .CTYPE_VALUE(CT_K)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_instr(req_instr), .req_wdata(req_wdata), .rd_data_o(rd_data_o),
    .undef_o(undef_o), .maint_pulse_o(maint_pulse_o),
    .maint_operand_o(maint_operand_o), .ctl_main_o(ctl_main_o),
    .ctl_aux_o(ctl_aux_o), .ttb_o(ttb_o), .dom_o(dom_o), .fstat_o(fstat_o),
    .faddr_o(faddr_o), .pid_o(pid_o), .cpacc_o(cpacc_o));

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R13";
  bit    cmp_on   = 1'b0;
  bit    done     = 1'b0;

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg [int];     // keyed by register number (1 = main, 101 = aux)
  logic [31:0] m_rd, m_oper;
  logic [9:0]  m_pulse;
  bit          m_undef;
  string       m_tag;

  // returns {known, pulses}; known=0 means undefined pair
  function automatic logic [10:0] maint_of(int crn, int op2, int crm);
    int key = op2 * 16 + crm;
    if (crn == 7) begin
      case (key)
        7:       return {1'b1, 10'b00_0000_0101};
        5:       return {1'b1, 10'b00_0000_0001};
        21:      return {1'b1, 10'b00_0000_0010};
        6:       return {1'b1, 10'b00_0000_0100};
        22:      return {1'b1, 10'b00_0000_1000};
        26:      return {1'b1, 10'b00_0001_0000};
        74:      return {1'b1, 10'b00_0010_0000};
        82:      return {1'b1, 10'b00_0000_0100};
        101:     return {1'b1, 10'b00_0000_0000};
        default: return 11'b0;
      endcase
    end
    case (key)
      7:       return {1'b1, 10'b01_0100_0000};
      5:       return {1'b1, 10'b00_0100_0000};
      21:      return {1'b1, 10'b00_1000_0000};
      6:       return {1'b1, 10'b01_0000_0000};
      22:      return {1'b1, 10'b10_0000_0000};
      default: return 11'b0;
    endcase
  endfunction

  function automatic logic [31:0] get(int k);
    return m_reg.exists(k) ? m_reg[k] : 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg.delete();
      m_rd = '0; m_oper = '0; m_pulse = '0; m_undef = 0;
      m_tag = cur_req;
    end else begin
      int crn, op2, crm;
      logic [10:0] mo;
      m_pulse = '0; m_undef = 0;
      m_tag = cur_req;
      crn = int'(req_instr[19:16]); op2 = int'(req_instr[7:5]); crm = int'(req_instr[3:0]);
      if (req_valid && req_write) begin
        case (crn)
          1:  if (op2 != 0) m_reg[101] = req_wdata & 32'h33; else m_reg[1] = req_wdata & 32'h3FFF;
          2:  m_reg[2]  = req_wdata & 32'hFFFF_C000;
          3:  m_reg[3]  = req_wdata;
          5:  m_reg[5]  = req_wdata & 32'h6FF;
          6:  m_reg[6]  = req_wdata;
          13: m_reg[13] = req_wdata & 32'hFE00_0000;
          15: m_reg[15] = req_wdata & 32'h3FF;
          7, 8: begin
            mo = maint_of(crn, op2, crm);
            if (!mo[10]) m_undef = 1;
            m_pulse = mo[9:0];
            if (mo[9:0] != 0) m_oper = req_wdata;
          end
          default: ;
        endcase
      end else if (req_valid) begin
        case (crn)
          0:  m_rd = (op2 != 0) ? CT_K : ID_K;
          1:  m_rd = (op2 != 0) ? get(101) : get(1);
          2, 3, 5, 6, 13, 15: m_rd = get(crn);
          default: m_undef = 1;
        endcase
      end
    end
  end

  // ---------------- comparison every clock ----------------
  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", m_tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("rd_data", rd_data_o, m_rd);
      chk("undef", {31'b0, undef_o}, {31'b0, m_undef});
      chk("pulse", {22'b0, maint_pulse_o}, {22'b0, m_pulse});
      if (m_pulse != 0) chk("operand", maint_operand_o, m_oper);
      chk("ctl_main", ctl_main_o, get(1));
      chk("ctl_aux", ctl_aux_o, get(101));
      chk("ttb", ttb_o, get(2));
      chk("dom", dom_o, get(3));
      chk("fstat", fstat_o, get(5));
      chk("faddr", faddr_o, get(6));
      chk("pid", pid_o, get(13));
      chk("cpacc", cpacc_o, get(15));
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(bit wr, int crn, int op2, int crm, logic [31:0] wd);
    logic [31:0] ins;
    @(negedge clk);
    ins = $urandom;               // R1: don't-care bits are random
    ins[19:16] = 4'(crn);
    ins[7:5]   = 3'(op2);
    ins[3:0]   = 4'(crm);
    req_valid = 1'b1; req_write = wr; req_instr = ins; req_wdata = wd;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_instr = $urandom; req_wdata = $urandom;
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    cur_req = "R13"; idle(2);

    cur_req = "R2";
    op(0, 0, 0, 0, '0); op(0, 0, 1, 0, '0); op(0, 0, 7, 3, '0); idle(3);

    cur_req = "R3";
    op(1, 1, 0, 0, 32'hFFFF_FFFF); op(1, 1, 1, 0, 32'hFFFF_FFFF);
    op(0, 1, 0, 0, '0); op(0, 1, 2, 0, '0);
    op(1, 1, 3, 9, 32'h0000_00CC); op(0, 1, 1, 0, '0); idle(1);

    cur_req = "R4";
    op(1, 2, 0, 0, 32'hFFFF_FFFF); op(1, 5, 0, 0, 32'hFFFF_FFFF);
    op(1, 13, 0, 0, 32'hFFFF_FFFF); op(1, 15, 0, 0, 32'hFFFF_FFFF);
    op(0, 2, 0, 0, '0); op(0, 5, 0, 0, '0); op(0, 15, 0, 0, '0);
    op(1, 2, 0, 0, 32'h1234_5678); op(0, 2, 0, 0, '0); idle(1);

    cur_req = "R5";
    op(1, 3, 0, 0, 32'hDEAD_BEEF); op(1, 6, 0, 0, 32'h8000_0001);
    op(0, 3, 0, 0, '0); op(0, 6, 0, 0, '0); idle(1);

    cur_req = "R12";
    op(1, 13, 0, 0, 32'h5A00_0000); op(1, 15, 0, 0, 32'h0000_02A5);
    op(0, 13, 0, 0, '0); idle(2);

    cur_req = "R6";
    op(1, 7, 0, 7, 32'h100); op(1, 7, 0, 5, 32'h104); op(1, 7, 1, 5, 32'h108);
    op(1, 7, 0, 6, 32'h10C); op(1, 7, 1, 6, 32'h110); op(1, 7, 1, 10, 32'h114);
    op(1, 7, 4, 10, 32'h118); op(1, 7, 5, 2, 32'h11C); idle(2);

    cur_req = "R7";
    op(1, 8, 0, 7, 32'h200); op(1, 8, 0, 5, 32'h204); op(1, 8, 1, 5, 32'h208);
    op(1, 8, 0, 6, 32'h20C); op(1, 8, 1, 6, 32'h210); idle(2);

    cur_req = "R8";
    op(1, 7, 1, 6, 32'hCAFE_0000); idle(1); op(1, 8, 1, 5, 32'hCAFE_0040); idle(3);

    cur_req = "R11";
    op(1, 7, 6, 5, 32'h0BAD_F00D); idle(2);

    cur_req = "R9";
    op(1, 7, 2, 5, 32'h1); op(1, 8, 1, 10, 32'h2); op(1, 8, 4, 10, 32'h3);
    op(1, 7, 0, 0, 32'h4); op(0, 7, 0, 7, '0); op(0, 4, 0, 0, '0);
    op(0, 14, 0, 0, '0); op(0, 8, 0, 5, '0); idle(2);

    cur_req = "R10";
    op(1, 0, 0, 0, 32'hFFFF_FFFF); op(1, 4, 0, 0, 32'hFFFF_FFFF);
    op(1, 9, 0, 0, 32'hFFFF_FFFF); op(1, 14, 0, 0, 32'hFFFF_FFFF);
    op(0, 0, 0, 0, '0); idle(2);

    cur_req = "R1";
    for (int i = 0; i < 400; i++) begin
      int sel = int'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) idle(1);
      else op(bit'($urandom_range(0, 1)), sel, int'($urandom_range(0, 7)),
              int'($urandom_range(0, 15)), $urandom);
    end
    idle(3);
    finish_up();
  end

endmodule